// File: doc/BRIEF.md
# Prioritized Interrupt Entry Sequencer

This block sits next to a small 8-bit microcontroller core and carries out the hardware part of taking an interrupt. It collects one-cycle pending pulses from the interrupt sources and from a reset request. Whenever the core's global enable flag is set and something is waiting, it accepts one request. The reset request wins over the hardware sources. Among the hardware sources, the lowest-numbered pending one wins.

Once a request is accepted, the sequencer stalls the core. It then saves the current word program counter on the data stack, least significant byte first, one byte per clock, through a byte-wide memory write port. The stack pointer is decremented after each byte. In a final load cycle it:
- writes back the new stack pointer,
- loads the program counter with the vector address,
- asks the core to clear its global enable flag,
- drops the pending bit it has just serviced.

The vector number is 0 for reset and source index plus one for hardware sources. It is scaled by a slot width of one or two words. The return address is 1, 2 or 3 bytes wide, set by a parameter.

Top module: `irq_entry_seq`

## Requirements
- R1: After synchronous reset the block is idle: `busy_o`, `mem_we_o`, `pc_we_o`, `done_o` and `irq_o` are 0, and `pend_o` and the reset-pending flag are clear.
- R2: No request is accepted while `gie_i` is 0. This holds for hardware sources and for the reset request alike. Requests that arrive in that time stay pending and are visible on `pend_o`.
- R3: When several hardware sources are pending at acceptance, the one with the lowest bit index is serviced. Its vector number is index + 1.
- R4: A pending reset request has priority over every hardware source and uses vector number 0.
- R5: In the load cycle, `pc_o` equals vector number × slot size. The slot size is 2 words when `LONG_SLOT`=1 and 1 word when it is 0.
- R6: The return address is written as `PC_BYTES` consecutive byte writes, one per cycle. Byte k carries `pc[8k+7:8k]`, so bit 0 is in the first write. Byte k goes to address `sp - k`. In the load cycle, `sp_o` equals `sp - PC_BYTES` with `sp_we_o` high.
- R7: `gie_clr_o` is high for exactly the load cycle, together with `done_o` and `pc_we_o`. That cycle follows the last stack write.
- R8: Only the serviced pending bit is cleared, when the load cycle ends. `irq_o` stays high while any hardware pending bit remains set and goes low only when none is left.
- R9: Source pulses that arrive while a sequence is running are added to the pending set and are not lost.
- R10: `busy_o` rises in the cycle after acceptance and stays high through the load cycle. It falls in the cycle after `done_o`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| src_set_i | input | NUM_SRC | One-cycle pulses marking hardware sources pending |
| rst_req_i | input | 1 | One-cycle pulse raising the reset request |
| gie_i | input | 1 | Core's global interrupt enable flag |
| pc_i | input | 8*PC_BYTES | Current word program counter (return address) |
| sp_i | input | SP_W | Current stack pointer |
| mem_we_o | output | 1 | Stack byte write strobe |
| mem_addr_o | output | SP_W | Stack byte write address |
| mem_wdata_o | output | 8 | Stack byte write data |
| pc_we_o | output | 1 | Program counter load strobe |
| pc_o | output | 8*PC_BYTES | New program counter (vector address) |
| sp_we_o | output | 1 | Stack pointer load strobe |
| sp_o | output | SP_W | New stack pointer |
| gie_clr_o | output | 1 | Request to clear the global enable flag |
| busy_o | output | 1 | Core stall; high while a sequence runs |
| done_o | output | 1 | Pulse in the final cycle of a sequence |
| pend_o | output | NUM_SRC | Hardware pending bits |
| irq_o | output | 1 | Hardware request line: any pending bit set |

## Verification
The bench sets one source while interrupts are masked. This shows that masking holds requests without losing them. It then loads three sources at once and drains them in turn. This separates lowest-index selection from arrival order, and checks that only the serviced bit is cleared each time. A reset request raised in the same cycle as source 0 shows that reset takes precedence and uses vector 0. A source that arrives on the very edge where another is accepted checks that late arrivals survive. Each entry uses a different return address and stack pointer, so byte order, address decrement and the final stack value are all exposed.

// File: rtl/irq_seq_pkg.sv
package irq_seq_pkg;

    typedef enum logic [2:0] {
        ST_IDLE  = 3'd0,
        ST_PUSH0 = 3'd1,
        ST_PUSH1 = 3'd2,
        ST_PUSH2 = 3'd3,
        ST_LOAD  = 3'd4
    } seq_state_e;

    // Request chosen at acceptance
    typedef struct packed {
        logic       is_rst;
        logic [4:0] idx;
    } pick_t;

    // Index of the lowest set bit (0 when none is set)
    function automatic logic [4:0] lowest_set(input logic [31:0] v);
        logic [4:0] r;
        r = 5'd0;
        for (int i = 31; i >= 0; i--) begin
            if (v[i]) r = 5'(i);
        end
        return r;
    endfunction

    // Next state after one pushed byte, given return-address width
    function automatic seq_state_e after_push(input seq_state_e s, input int unsigned nbytes);
        seq_state_e n;
        case (s)
            ST_PUSH0: n = (nbytes > 1) ? ST_PUSH1 : ST_LOAD;
            ST_PUSH1: n = (nbytes > 2) ? ST_PUSH2 : ST_LOAD;
            default:  n = ST_LOAD;
        endcase
        return n;
    endfunction

endpackage

// File: rtl/irq_pend.sv
module irq_pend
    import irq_seq_pkg::*;
#(
    parameter int NUM_SRC = 8,
    parameter int IDX_W   = 3
) (
    input  logic               clk,
    input  logic               rst,
    input  logic [NUM_SRC-1:0] src_set_i,
    input  logic               rst_req_i,
    input  logic               clr_hw_i,
    input  logic [IDX_W-1:0]   clr_idx_i,
    input  logic               clr_rst_i,
    output logic [NUM_SRC-1:0] pend_o,
    output logic               rst_pend_o,
    output pick_t              pick_o
);

    logic [NUM_SRC-1:0] pend_q;
    logic               rst_q;
    logic [NUM_SRC-1:0] clr_mask;

    assign clr_mask = clr_hw_i ? (NUM_SRC'(1) << clr_idx_i) : '0;

    always_ff @(posedge clk) begin
        if (rst) begin
            pend_q <= '0;
            rst_q  <= 1'b0;
        end else begin
            // new arrivals win over a same-cycle clear
            pend_q <= (pend_q & ~clr_mask) | src_set_i;
            rst_q  <= (rst_q & ~clr_rst_i) | rst_req_i;
        end
    end

    always_comb begin
        pick_o.is_rst = rst_q;
        pick_o.idx    = lowest_set(32'(pend_q));
    end

    assign pend_o     = pend_q;
    assign rst_pend_o = rst_q;

endmodule

// File: rtl/irq_push.sv
module irq_push
    import irq_seq_pkg::*;
#(
    parameter int PC_BYTES = 3,
    parameter int SP_W     = 16,
    localparam int PC_W    = 8 * PC_BYTES
) (
    input  logic            clk,
    input  logic            rst,
    input  logic            start_i,
    input  logic [PC_W-1:0] pc_i,
    input  logic [SP_W-1:0] sp_i,
    output logic            mem_we_o,
    output logic [SP_W-1:0] mem_addr_o,
    output logic [7:0]      mem_wdata_o,
    output logic            load_o,
    output logic            busy_o,
    output logic [SP_W-1:0] sp_o
);

    seq_state_e      state_q;
    logic [PC_W-1:0] pc_q;
    logic [SP_W-1:0] sp_q;
    logic [2:0][7:0] pc_bytes;

    assign pc_bytes = 24'(pc_q);

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q <= ST_IDLE;
            pc_q    <= '0;
            sp_q    <= '0;
        end else begin
            case (state_q)
                ST_IDLE: begin
                    if (start_i) begin
                        state_q <= ST_PUSH0;
                        pc_q    <= pc_i;
                        sp_q    <= sp_i;
                    end
                end
                ST_PUSH0, ST_PUSH1, ST_PUSH2: begin
                    sp_q    <= sp_q - 1'b1;
                    state_q <= after_push(state_q, PC_BYTES);
                end
                default: state_q <= ST_IDLE;
            endcase
        end
    end

    always_comb begin
        mem_we_o    = 1'b0;
        mem_wdata_o = 8'h00;
        case (state_q)
            ST_PUSH0: begin mem_we_o = 1'b1; mem_wdata_o = pc_bytes[0]; end
            ST_PUSH1: begin mem_we_o = 1'b1; mem_wdata_o = pc_bytes[1]; end
            ST_PUSH2: begin mem_we_o = 1'b1; mem_wdata_o = pc_bytes[2]; end
            default:  ;
        endcase
    end

    assign mem_addr_o = sp_q;
    assign sp_o       = sp_q;
    assign load_o     = (state_q == ST_LOAD);
    assign busy_o     = (state_q != ST_IDLE);

endmodule

// File: rtl/irq_entry_seq.sv
module irq_entry_seq
    import irq_seq_pkg::*;
#(
    parameter int NUM_SRC   = 8,
    parameter int PC_BYTES  = 3,
    parameter int SP_W      = 16,
    parameter bit LONG_SLOT = 1'b1,
    localparam int PC_W     = 8 * PC_BYTES
) (
    input  logic               clk,
    input  logic               rst,
    input  logic [NUM_SRC-1:0] src_set_i,
    input  logic               rst_req_i,
    input  logic               gie_i,
    input  logic [PC_W-1:0]    pc_i,
    input  logic [SP_W-1:0]    sp_i,
    output logic               mem_we_o,
    output logic [SP_W-1:0]    mem_addr_o,
    output logic [7:0]         mem_wdata_o,
    output logic               pc_we_o,
    output logic [PC_W-1:0]    pc_o,
    output logic               sp_we_o,
    output logic [SP_W-1:0]    sp_o,
    output logic               gie_clr_o,
    output logic               busy_o,
    output logic               done_o,
    output logic [NUM_SRC-1:0] pend_o,
    output logic               irq_o
);

    localparam int IDX_W      = (NUM_SRC > 1) ? $clog2(NUM_SRC) : 1;
    localparam int VEC_W      = $clog2(NUM_SRC + 1);
    localparam int SLOT_SHIFT = LONG_SLOT ? 1 : 0;

    pick_t            pick;
    logic             rst_pend;
    logic             accept;
    logic             load;
    logic             busy;
    logic             is_rst_q;
    logic [IDX_W-1:0] idx_q;
    logic [VEC_W-1:0] vec_q;

    irq_pend #(.NUM_SRC(NUM_SRC), .IDX_W(IDX_W)) u_pend (
        .clk        (clk),
        .rst        (rst),
        .src_set_i  (src_set_i),
        .rst_req_i  (rst_req_i),
        .clr_hw_i   (load & ~is_rst_q),
        .clr_idx_i  (idx_q),
        .clr_rst_i  (load & is_rst_q),
        .pend_o     (pend_o),
        .rst_pend_o (rst_pend),
        .pick_o     (pick)
    );

    assign irq_o  = |pend_o;
    assign accept = ~busy & gie_i & (rst_pend | irq_o);

    always_ff @(posedge clk) begin
        if (rst) begin
            is_rst_q <= 1'b0;
            idx_q    <= '0;
            vec_q    <= '0;
        end else if (accept) begin
            is_rst_q <= pick.is_rst;
            idx_q    <= IDX_W'(pick.idx);
            vec_q    <= pick.is_rst ? '0 : VEC_W'(pick.idx) + 1'b1;
        end
    end

    irq_push #(.PC_BYTES(PC_BYTES), .SP_W(SP_W)) u_push (
        .clk         (clk),
        .rst         (rst),
        .start_i     (accept),
        .pc_i        (pc_i),
        .sp_i        (sp_i),
        .mem_we_o    (mem_we_o),
        .mem_addr_o  (mem_addr_o),
        .mem_wdata_o (mem_wdata_o),
        .load_o      (load),
        .busy_o      (busy),
        .sp_o        (sp_o)
    );

    assign pc_o      = PC_W'(vec_q) << SLOT_SHIFT;
    assign pc_we_o   = load;
    assign sp_we_o   = load;
    assign gie_clr_o = load;
    assign done_o    = load;
    assign busy_o    = busy;

endmodule

// File: rtl/irq_entry_seq_chk.sv
module irq_entry_seq_chk #(
    parameter int NUM_SRC = 8,
    parameter int SP_W    = 16
) (
    input logic               clk,
    input logic               rst,
    input logic               gie_i,
    input logic               busy_o,
    input logic               done_o,
    input logic               gie_clr_o,
    input logic               pc_we_o,
    input logic               mem_we_o,
    input logic [SP_W-1:0]    mem_addr_o,
    input logic [NUM_SRC-1:0] pend_o,
    input logic               irq_o
);

    // R2
    masked_idle_chk: assert property (@(posedge clk) disable iff (rst)
        (!gie_i && !busy_o) |=> !busy_o);

    // R6
    push_dec_chk: assert property (@(posedge clk) disable iff (rst)
        (mem_we_o && $past(mem_we_o)) |-> (mem_addr_o == $past(mem_addr_o) - 1'b1));

    // R7
    clr_after_push_chk: assert property (@(posedge clk) disable iff (rst)
        gie_clr_o |-> $past(mem_we_o));

    // R7
    load_excl_chk: assert property (@(posedge clk) disable iff (rst)
        $onehot0({mem_we_o, pc_we_o}));

    // R8
    irq_hold_chk: assert property (@(posedge clk) disable iff (rst)
        (irq_o && !done_o) |=> irq_o);

    // R10
    done_idle_chk: assert property (@(posedge clk) disable iff (rst)
        done_o |=> !busy_o);

    // R10
    write_busy_chk: assert property (@(posedge clk) disable iff (rst)
        mem_we_o |-> busy_o);

endmodule

bind irq_entry_seq irq_entry_seq_chk #(.NUM_SRC(NUM_SRC), .SP_W(SP_W)) u_chk (
    .clk        (clk),
    .rst        (rst),
    .gie_i      (gie_i),
    .busy_o     (busy_o),
    .done_o     (done_o),
    .gie_clr_o  (gie_clr_o),
    .pc_we_o    (pc_we_o),
    .mem_we_o   (mem_we_o),
    .mem_addr_o (mem_addr_o),
    .pend_o     (pend_o),
    .irq_o      (irq_o)
);

// File: tb/tb_irq_entry_seq.sv
`timescale 1ns/1ps
module tb_irq_entry_seq;

    localparam int NUM_SRC  = 8;
    localparam int PC_BYTES = 3;
    localparam int SP_W     = 16;
    localparam bit LONG     = 1'b1;
    localparam int PC_W     = 8 * PC_BYTES;
    localparam int SLOT     = LONG ? 2 : 1;

    logic               clk = 1'b0;
    logic               rst = 1'b1;
    logic [NUM_SRC-1:0] src_set = '0;
    logic               rst_req = 1'b0;
    logic               gie = 1'b0;
    logic [PC_W-1:0]    pc_in = '0;
    logic [SP_W-1:0]    sp_in = '0;
    logic               mem_we, pc_we, sp_we, gie_clr, busy, done, irq;
    logic [SP_W-1:0]    mem_addr, sp_out;
    logic [7:0]         mem_wdata;
    logic [PC_W-1:0]    pc_out;
    logic [NUM_SRC-1:0] pend;

    int checks = 0;
    int errors = 0;

    always #2.5 clk = ~clk;

    irq_entry_seq #(.NUM_SRC(NUM_SRC), .PC_BYTES(PC_BYTES), .SP_W(SP_W), .LONG_SLOT(LONG)) dut (
        .clk(clk), .rst(rst), .src_set_i(src_set), .rst_req_i(rst_req), .gie_i(gie),
        .pc_i(pc_in), .sp_i(sp_in), .mem_we_o(mem_we), .mem_addr_o(mem_addr),
        .mem_wdata_o(mem_wdata), .pc_we_o(pc_we), .pc_o(pc_out), .sp_we_o(sp_we),
        .sp_o(sp_out), .gie_clr_o(gie_clr), .busy_o(busy), .done_o(done),
        .pend_o(pend), .irq_o(irq)
    );

    task automatic chk(input bit ok, input string req, input string what,
                       input longint act, input longint exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
        end
    endtask

    task automatic pulse_src(input logic [NUM_SRC-1:0] m, input logic r);
        src_set = m;
        rst_req = r;
        @(negedge clk);
        src_set = '0;
        rst_req = 1'b0;
    endtask

    task automatic idle(input int n);
        repeat (n) @(negedge clk);
    endtask

    // Follows one entry sequence; the caller has set pc_in/sp_in and gie
    task automatic run_entry(input int vec, input logic [PC_W-1:0] pc,
                             input logic [SP_W-1:0] sp, input string req);
        int guard = 0;
        int nw = 0;
        while (!busy && guard < 10) begin @(negedge clk); guard++; end
        chk(busy, "R10", "busy after accept", busy, 1);
        guard = 0;
        while (!pc_we && guard < 10) begin
            if (mem_we) begin
                chk(mem_addr == sp - SP_W'(nw), "R6", "push address", mem_addr, sp - SP_W'(nw));
                chk(mem_wdata == pc[8*nw +: 8], "R6", "push byte", mem_wdata, pc[8*nw +: 8]);
                nw++;
            end
            @(negedge clk);
            guard++;
        end
        chk(nw == PC_BYTES, "R6", "push count", nw, PC_BYTES);
        chk(pc_out == PC_W'(vec * SLOT), req, "vector pc", pc_out, vec * SLOT);
        chk(pc_out == PC_W'(vec * SLOT), "R5", "pc scaled by slot", pc_out, vec * SLOT);
        chk(sp_we && sp_out == sp - SP_W'(PC_BYTES), "R6", "final sp", sp_out, sp - SP_W'(PC_BYTES));
        chk(gie_clr && done && busy, "R7", "load cycle strobes", {gie_clr, done, busy}, 3'b111);
        gie = 1'b0;
        @(negedge clk);
        chk(!busy && !done && !gie_clr, "R10", "idle after done", {busy, done, gie_clr}, 0);
    endtask

    task automatic t_reset();
        chk(!busy && !mem_we && !pc_we && !done && !irq && pend == '0, "R1", "reset state",
            {busy, mem_we, pc_we, done, irq, pend}, 0);
    endtask

    task automatic t_masked();
        gie = 1'b0;
        pulse_src(8'h10, 1'b0);
        idle(5);
        chk(!busy, "R2", "no accept while masked", busy, 0);
        chk(pend == 8'h10, "R2", "masked source held", pend, 8'h10);
        chk(irq, "R8", "irq line with pending", irq, 1);
        pc_in = 24'h3C5A96; sp_in = 16'h08FF;
        gie = 1'b1;
        run_entry(5, 24'h3C5A96, 16'h08FF, "R3");
        chk(pend == '0 && !irq, "R8", "cleared after service", {irq, pend}, 0);
    endtask

    task automatic t_priority();
        gie = 1'b0;
        pulse_src(8'hA4, 1'b0);
        idle(1);
        pc_in = 24'h123456; sp_in = 16'h0400;
        gie = 1'b1;
        run_entry(3, 24'h123456, 16'h0400, "R3");
        chk(pend == 8'hA0, "R8", "only serviced bit cleared", pend, 8'hA0);
        chk(irq, "R8", "irq stays with remaining", irq, 1);
        pc_in = 24'hABCDEF; sp_in = 16'h03FD;
        gie = 1'b1;
        run_entry(6, 24'hABCDEF, 16'h03FD, "R3");
        chk(pend == 8'h80, "R3", "next lowest remaining", pend, 8'h80);
        pc_in = 24'h000001; sp_in = 16'h0001;
        gie = 1'b1;
        run_entry(8, 24'h000001, 16'h0001, "R3");
        chk(pend == '0 && !irq, "R8", "irq drops at empty", {irq, pend}, 0);
    endtask

    task automatic t_reset_prio();
        gie = 1'b0;
        pulse_src(8'h01, 1'b1);
        idle(4);
        chk(!busy, "R2", "reset request masked", busy, 0);
        pc_in = 24'hFEDCBA; sp_in = 16'h1000;
        gie = 1'b1;
        run_entry(0, 24'hFEDCBA, 16'h1000, "R4");
        chk(pend == 8'h01, "R4", "source kept behind reset", pend, 8'h01);
        pc_in = 24'h00FF00; sp_in = 16'h0FFD;
        gie = 1'b1;
        run_entry(1, 24'h00FF00, 16'h0FFD, "R4");
        idle(3);
        chk(!busy, "R4", "reset request consumed", busy, 0);
    endtask

    task automatic t_arrival();
        pc_in = 24'h5A5A5A; sp_in = 16'h0200;
        gie = 1'b1;
        pulse_src(8'h08, 1'b0);
        pulse_src(8'h02, 1'b0);
        run_entry(4, 24'h5A5A5A, 16'h0200, "R9");
        chk(pend == 8'h02, "R9", "late arrival kept", pend, 8'h02);
        pc_in = 24'h0A0B0C; sp_in = 16'h01FD;
        gie = 1'b1;
        run_entry(2, 24'h0A0B0C, 16'h01FD, "R9");
        chk(pend == '0, "R9", "late arrival serviced", pend, 0);
    endtask

    initial begin
        repeat (40000) @(posedge clk);
        errors++;
        $display("FAIL watchdog expired actual=running expected=finished");
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        rst = 1'b1;
        idle(3);
        rst = 1'b0;
        @(negedge clk);
        t_reset();
        t_masked();
        t_priority();
        t_reset_prio();
        t_arrival();
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule